// File: doc/BRIEF.md
# Auto-Reload Up/Down Timer Counter

This block is a timer and event counter with a programmable reload value. Each counting step either follows the clock or follows a rising edge of an external event input. The step can move the count up or down. In gated mode a step is only taken while a gate input is high, so the final count measures how long a pulse lasted.

When the count passes its end point it reloads from the reload register. Going up, the end point is all-ones. Going down, it is zero. That reloading step raises a sticky interrupt flag and pulses a one-cycle overflow tick, which a serial port can use as its 16x oversampling clock. A compare register drives a pulse-width output that is high while the count is below the compare value. The compare value takes effect at each reload, so a period is never cut short mid-way.

Software reaches the block through a plain write port and a combinational read port. Neither port has a handshake: a write takes effect at the clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` in the same cycle. Nothing flows through the block as a stream, so it has no valid/ready interface.

Top module: `updown_reload_timer`

## Requirements
- R1: After reset the count, reload, compare and control registers are zero, the interrupt flag is low, `pwm_out` is low and `ovf_tick` is low.
- R2: With run set, internal source and gate disabled, the count rises by one on every clock; a step taken from all-ones loads the reload value instead.
- R3: With the down bit set, the count falls by one per step; a step taken from zero loads the reload value instead.
- R4: `ovf_tick` is high during exactly the cycles whose closing clock edge performs a reloading step, and low otherwise.
- R5: Each reloading step sets the interrupt flag (`irq`), which stays set until a control write with bit 4 = 1; if a reload and such a clear fall on the same edge, the flag ends up set.
- R6: With the external source bit set, one step is taken per rising edge of `ext_evt`. The edge passes through a two-flop synchronizer and an edge register, so the count changes on the third clock edge after the input rises. Levels must stay stable for at least one clock period.
- R7: `pwm_out` is high while the count is below the active compare value; the active compare value copies the compare register on every reloading step and is zero after reset.
- R8: Register addresses. Address 0 is control: bit0 run, bit1 down, bit2 external source, bit3 gate enable, bit4 interrupt clear (write only). Reading address 0 returns the four control bits in [3:0] and the flag in bit 4. Address 1 is reload, address 2 is compare, and address 3 is the count. A count write overrides any step on the same edge.
- R9: With gate enable set, a step is taken only while `gate_in`, delayed by a two-flop synchronizer, is high.
- R10: With run clear, the count holds its value and `ovf_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WIDTH | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WIDTH | Combinational read data |
| ext_evt | input | 1 | External event input (asynchronous) |
| gate_in | input | 1 | Gate input for pulse measurement (asynchronous) |
| irq | output | 1 | Sticky interrupt request flag |
| ovf_tick | output | 1 | One-cycle pulse on each reloading step |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The bench builds the block with WIDTH = 16, the width the counter is meant for. It reaches the all-ones and zero end points within a few cycles by writing the count directly just below them. That makes repeated reloads, compare handover and the clear-versus-set collision visible without waiting 65536 cycles. Its behavioural model tracks the synchronizer delays of both asynchronous inputs, so the third-edge timing of events and the two-cycle gate delay are compared on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic gate_en;
    logic ext_src;
    logic down;
    logic run;
  } tmr_ctrl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_CMP    = 2'd2;
  localparam logic [1:0] ADDR_COUNT  = 2'd3;
  localparam int         CLR_BIT     = 4;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~prev;

  // R6
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] reload,
  input  logic             irq_clr,
  output logic [WIDTH-1:0] cnt,
  output logic             wrap,
  output logic             irq
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic terminal;
  assign terminal = down ? (cnt == '0) : (cnt == TOP);
  assign wrap     = step & terminal;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (wrap)   cnt <= reload;
    else if (step)   cnt <= down ? cnt - 1'b1 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       irq <= 1'b0;
    else if (wrap)    irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;

  // R2
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (cnt == $past(reload)));
  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> irq);
  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && down && !wrap && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] cmp_reg,
  input  logic             wrap,
  output logic             pwm
);
  logic [WIDTH-1:0] cmp_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cmp_act <= '0;
    else if (wrap) cmp_act <= cmp_reg;

  assign pwm = cnt < cmp_act;

  // R7
  cmp_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cmp_act == $past(cmp_reg)));
  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(cmp_act));
endmodule

// File: rtl/updown_reload_timer.sv
module updown_reload_timer
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             ext_evt,
  input  logic             gate_in,
  output logic             irq,
  output logic             ovf_tick,
  output logic             pwm_out
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);

  tmr_ctrl_t        ctrl;
  logic [WIDTH-1:0] reload_q, cmp_q, cnt;
  logic             evt_rise, gate_lvl, evt_lvl_unused, gate_rise_unused;
  logic             step, wrap, wr_ctrl, wr_cnt, irq_clr;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
  assign irq_clr = wr_ctrl && wr_data[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl     <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL:   ctrl     <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_RELOAD: reload_q <= wr_data;
        ADDR_CMP:    cmp_q    <= wr_data;
        default:     ;
      endcase
    end

  tmr_sync_edge #(.STAGES(2)) u_evt_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_evt),
    .level(evt_lvl_unused), .rise(evt_rise));

  tmr_sync_edge #(.STAGES(2)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .din(gate_in),
    .level(gate_lvl), .rise(gate_rise_unused));

  assign step = ctrl.run
              && (ctrl.ext_src ? evt_rise : 1'b1)
              && (ctrl.gate_en ? gate_lvl : 1'b1);

  tmr_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .down(ctrl.down),
    .load(wr_cnt), .load_val(wr_data), .reload(reload_q),
    .irq_clr(irq_clr), .cnt(cnt), .wrap(wrap), .irq(irq));

  tmr_pwm #(.WIDTH(WIDTH)) u_pwm (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp_reg(cmp_q),
    .wrap(wrap), .pwm(pwm_out));

  assign ovf_tick = wrap;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CTRL:   rd_data[CTRL_W:0] = {irq, ctrl};
      ADDR_RELOAD: rd_data = reload_q;
      ADDR_CMP:    rd_data = cmp_q;
      default:     rd_data = cnt;
    endcase
  end

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !wr_cnt) |=> $stable(cnt));
  // R4
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_tick |-> ctrl.run);
endmodule

// File: tb/test_updown_reload_timer.sv
module test_updown_reload_timer;
  localparam int W = 16;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 3;
  logic [W-1:0] wr_data = 0, rd_data;
  logic ext_evt = 0, gate_in = 0;
  logic irq, ovf_tick, pwm_out;

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  updown_reload_timer #(.WIDTH(W)) i_updown_reload_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_evt(ext_evt), .gate_in(gate_in),
    .irq(irq), .ovf_tick(ovf_tick), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  // behavioural reference model
  logic [W-1:0] m_cnt, m_rel, m_cmp, m_cmpa;
  logic m_run, m_down, m_ext, m_gate, m_irq;
  logic e1, e2, e3, g1, g2;

  function automatic logic m_tick();
    return m_run && (m_ext ? (e2 && !e3) : 1'b1) && (m_gate ? g2 : 1'b1);
  endfunction
  function automatic logic m_wrap();
    return m_tick() && (m_down ? (m_cnt == 0) : (m_cnt == MAXV));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_cmp = 0; m_cmpa = 0;
      {m_run, m_down, m_ext, m_gate, m_irq} = '0;
      {e1, e2, e3, g1, g2} = '0;
    end else begin
      logic t, w;
      t = m_tick(); w = m_wrap();
      if (w) begin m_irq = 1; m_cmpa = m_cmp; end
      else if (wr_en && wr_addr == 0 && wr_data[4]) m_irq = 0;
      if (wr_en && wr_addr == 3) m_cnt = wr_data;
      else if (w) m_cnt = m_rel;
      else if (t) m_cnt = m_down ? m_cnt - 1 : m_cnt + 1;
      if (wr_en && wr_addr == 0) {m_gate, m_ext, m_down, m_run} = wr_data[3:0];
      if (wr_en && wr_addr == 1) m_rel = wr_data;
      if (wr_en && wr_addr == 2) m_cmp = wr_data;
      e3 = e2; e2 = e1; e1 = ext_evt; g2 = g1; g1 = gate_in;
    end
  end

  task automatic check1(string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [W-1:0] exp_rd;
      case (rd_addr)
        2'd0: exp_rd = W'({m_irq, m_gate, m_ext, m_down, m_run});
        2'd1: exp_rd = m_rel;
        2'd2: exp_rd = m_cmp;
        default: exp_rd = m_cnt;
      endcase
      check1("rd_data", rd_data, exp_rd);
      check1("irq", W'(irq), W'(m_irq));
      check1("ovf_tick", W'(ovf_tick), W'(m_wrap()));
      check1("pwm_out", W'(pwm_out), W'(m_cnt < m_cmpa));
    end
    if (cycles > 100000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  initial begin
    idle(2);
    // R1: reset values, scanning every read address
    cur_req = "R1";
    rst_n = 1; #1;
    for (int a = 0; a < 4; a++) begin rd_addr = a[1:0]; idle(1); end
    rd_addr = 3;

    // R8: register readback
    cur_req = "R8";
    wr(1, 16'hFFF0); wr(2, 16'hFFF8); wr(3, 16'hFFF0);
    for (int a = 0; a < 4; a++) begin rd_addr = a[1:0]; idle(1); end
    rd_addr = 3;

    // R2 R4 R7: up counting with reloads and pwm
    cur_req = "R2_R4_R7";
    wr(0, 16'h0001);
    idle(40);
    wr(2, 16'hFFF4); idle(40);

    // R5: clear, then clear colliding with a reload
    cur_req = "R5";
    rd_addr = 0;
    wr(0, 16'h0011); idle(2);
    wr(0, 16'h0000); wr(3, MAXV); wr(0, 16'h0001);
    wr(0, 16'h0011); idle(3);
    rd_addr = 3;

    // R8: count write overrides a step
    cur_req = "R8";
    wr(3, 16'h1234); idle(3);

    // R10: run clear holds
    cur_req = "R10";
    wr(0, 16'h0000); idle(10);

    // R3: down counting through zero
    cur_req = "R3";
    wr(1, 16'h000A); wr(2, 16'h0004); wr(3, 16'h0005);
    wr(0, 16'h0003); idle(30);

    // R6: external event edges at varied spacing
    cur_req = "R6";
    wr(0, 16'h0000); wr(1, 16'hFFFD); wr(3, 16'hFFFC);
    wr(0, 16'h0005);
    for (int k = 0; k < 8; k++) begin
      ext_evt = 1; idle(2 + k % 3);
      ext_evt = 0; idle(2 + (k * 2) % 5);
    end
    idle(5);

    // R9: gated measurement of pulse widths
    cur_req = "R9";
    wr(0, 16'h0000); wr(3, 16'h0000); wr(0, 16'h0009);
    gate_in = 1; idle(7); gate_in = 0; idle(6);
    gate_in = 1; idle(3); gate_in = 0; idle(6);
    wr(0, 16'h000B); wr(3, 16'h0010);
    gate_in = 1; idle(5); gate_in = 0; idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule